// File: doc/BRIEF.md
# Auxiliary Clock Pin Router and Lock Flag Driver

This block sits between a clock synthesiser and two output pads. It computes the data bit and the driver enable for a main clock pad and for an auxiliary pad. The auxiliary pad can carry any one of four sources: the timing reference, the frequency reference, the PLL output, or a flag that reports loss of lock. The clocks come in as ordinary logic signals, and the block passes them through combinational gating.

A single external mode pin takes its meaning from a 3-bit configuration code. Depending on that code, the pin turns off the main driver, the auxiliary driver or both, or it forces the auxiliary source to the PLL output. The lock flag is driven either push-pull and active high, or open-drain and active low. The main clock can be held low while lock is lost. When it is held, it starts again cleanly on a rising edge of the PLL clock once lock is back.

The mode pin is asynchronous, so it passes through a reset-cleared synchronizer clocked by the system clock `clk`. Lock status and reference presence are taken to be in the `clk` domain already. The block has no streaming data path, so it has no valid/ready handshake; all of its pins are plain control and status.

Top module: `clkout_ctrl`

## Requirements
- R1: The `aux_src` code selects the auxiliary pad source: 0 the timing reference, 1 the frequency reference, 2 the PLL clock, 3 the lock flag. This holds while no override or disable is in effect.
- R2: With `m2_cfg`=0, a high synchronized mode pin sets `main_oe`=0 and `main_data`=0 and leaves the auxiliary pad alone. Whenever any driver is disabled, its enable is 0 and its data is 0.
- R3: With `m2_cfg`=1, a high synchronized mode pin disables only the auxiliary pad.
- R4: With `m2_cfg`=2, a high synchronized mode pin disables both pads. With a low pin, every code leaves both pads enabled, apart from the open-drain lock flag rule in R8.
- R5: With `m2_cfg`=7, a high synchronized mode pin forces the auxiliary source to the PLL clock whatever `aux_src` holds, and disables nothing. With a low pin, `aux_src` applies.
- R6: With `m2_cfg` 3, 4, 5 or 6, the mode pin has no effect on either pad.
- R7: With `lock_od`=0, a lock flag that has been routed out drives `aux_oe`=1, with `aux_data`=1 when unlocked and 0 when locked.
- R8: With `lock_od`=1, a lock flag that has been routed out drives `aux_data`=0, with `aux_oe`=1 when unlocked and `aux_oe`=0 (high impedance) when locked.
- R9: Lock is reported only when `pll_locked`=1 and `tref_present`=1. With `tref_present`=0 the flag shows unlocked.
- R10: With `run_unlocked`=0 and `pll_locked`=0, `main_data` is held at 0. After lock returns, `main_data` stays 0 until the next rising edge of `pll_clk`, then follows `pll_clk`.
- R11: With `run_unlocked`=1, `main_data` follows `pll_clk` after the next rising edge of `pll_clk`, whatever the lock state.
- R12: A change on `mode_pin` reaches the pads after SYNC_STAGES rising edges of `clk` (2 by default). During and just after reset, the synchronized pin reads 0, so both pads are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the mode pin synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| tref_clk | input | 1 | Timing reference clock, treated as logic |
| fref_clk | input | 1 | Frequency reference clock, treated as logic |
| pll_clk | input | 1 | PLL output clock |
| pll_locked | input | 1 | PLL lock status, high when locked |
| tref_present | input | 1 | Timing reference is present |
| mode_pin | input | 1 | Asynchronous external mode pin |
| m2_cfg | input | 3 | Meaning of the mode pin |
| aux_src | input | 2 | Auxiliary pad source select |
| lock_od | input | 1 | 0 push-pull active-high flag, 1 open-drain active-low flag |
| run_unlocked | input | 1 | 1 keeps the main clock running while unlocked |
| main_data | output | 1 | Main pad data |
| main_oe | output | 1 | Main pad driver enable (0 is high impedance) |
| aux_data | output | 1 | Auxiliary pad data |
| aux_oe | output | 1 | Auxiliary pad driver enable (0 is high impedance) |

## Verification
The hardest state to reach from the ports is the interval just after lock returns, before the next PLL rising edge. In that interval the main pad must stay low even though every static condition now allows it to run. The bench holds `pll_clk` high while it raises lock, checks that the output is still low, and only then drives a low-then-high PLL pulse. In the exhaustive sweep it always settles the level inputs before it moves `pll_clk`. A reference model of the gate, kept in the bench, records whether a qualifying rising edge has happened since the last hold.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int SRC_W = 2;
  localparam int CFG_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_TREF = 2'd0,
    SRC_FREF = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_LOCK = 2'd3
  } aux_src_e;

  typedef enum logic [CFG_W-1:0] {
    PIN_OFF_MAIN  = 3'd0,
    PIN_OFF_AUX   = 3'd1,
    PIN_OFF_BOTH  = 3'd2,
    PIN_IDLE_3    = 3'd3,
    PIN_IDLE_4    = 3'd4,
    PIN_IDLE_5    = 3'd5,
    PIN_IDLE_6    = 3'd6,
    PIN_FORCE_PLL = 3'd7
  } pin_cfg_e;

  typedef struct packed {
    logic off_main;
    logic off_aux;
    logic force_pll;
  } pin_act_t;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_mode_dec.sv
module clkout_mode_dec
  import clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             pin_sync,
  output pin_act_t         act
);
  pin_cfg_e code;
  assign code = pin_cfg_e'(cfg);

  always_comb begin
    act = '0;
    if (pin_sync) begin
      unique case (code)
        PIN_OFF_MAIN:  act.off_main  = 1'b1;
        PIN_OFF_AUX:   act.off_aux   = 1'b1;
        PIN_OFF_BOTH:  begin
          act.off_main = 1'b1;
          act.off_aux  = 1'b1;
        end
        PIN_FORCE_PLL: act.force_pll = 1'b1;
        default:       act = '0;
      endcase
    end
  end

  AST_ACTION_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (act.off_main || act.off_aux || act.force_pll) |-> pin_sync); // R4
  AST_FORCE_NOT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    act.force_pll |-> (!act.off_main && !act.off_aux)); // R5
endmodule

// File: rtl/clkout_lock_fmt.sv
module clkout_lock_fmt (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_locked,
  input  logic tref_present,
  input  logic od_mode,
  output logic flag_data,
  output logic flag_oe
);
  logic unlocked;

  assign unlocked = !(pll_locked && tref_present);

  always_comb begin
    if (od_mode) begin
      flag_data = 1'b0;
      flag_oe   = unlocked;
    end else begin
      flag_data = unlocked;
      flag_oe   = 1'b1;
    end
  end

  AST_NO_TREF_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tref_present && !od_mode) |-> (flag_data && flag_oe)); // R9
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> !flag_data); // R8
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_clk,
  input  logic pll_locked,
  input  logic run_unlocked,
  output logic gated
);
  logic hold;
  logic clr;
  logic en;

  assign hold = !pll_locked && !run_unlocked;
  assign clr  = !rst_n || hold;

  always_ff @(posedge pll_clk or posedge clr) begin
    if (clr) en <= 1'b0;
    else     en <= 1'b1;
  end

  assign gated = pll_clk && en;

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !gated); // R10
  AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> pll_clk); // R11
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tref_clk,
  input  logic             fref_clk,
  input  logic             pll_clk,
  input  logic             pll_locked,
  input  logic             tref_present,
  input  logic             mode_pin,
  input  logic [CFG_W-1:0] m2_cfg,
  input  logic [SRC_W-1:0] aux_src,
  input  logic             lock_od,
  input  logic             run_unlocked,
  output logic             main_data,
  output logic             main_oe,
  output logic             aux_data,
  output logic             aux_oe
);
  logic     pin_sync;
  pin_act_t act;
  logic     flag_data;
  logic     flag_oe;
  logic     gated;
  aux_src_e sel;
  logic     mux_data;
  logic     mux_oe;

  clkout_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(mode_pin), .q(pin_sync)
  );

  clkout_mode_dec dec_i (
    .clk(clk), .rst_n(rst_n), .cfg(m2_cfg), .pin_sync(pin_sync), .act(act)
  );

  clkout_lock_fmt lock_i (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .tref_present(tref_present), .od_mode(lock_od),
    .flag_data(flag_data), .flag_oe(flag_oe)
  );

  clkout_gate gate_i (
    .clk(clk), .rst_n(rst_n), .pll_clk(pll_clk), .pll_locked(pll_locked),
    .run_unlocked(run_unlocked), .gated(gated)
  );

  assign sel = act.force_pll ? SRC_PLL : aux_src_e'(aux_src);

  always_comb begin
    mux_oe = 1'b1;
    unique case (sel)
      SRC_TREF: mux_data = tref_clk;
      SRC_FREF: mux_data = fref_clk;
      SRC_PLL:  mux_data = pll_clk;
      SRC_LOCK: begin
        mux_data = flag_data;
        mux_oe   = flag_oe;
      end
      default:  mux_data = 1'b0;
    endcase
  end

  assign aux_data  = act.off_aux  ? 1'b0 : mux_data;
  assign aux_oe    = act.off_aux  ? 1'b0 : mux_oe;
  assign main_data = act.off_main ? 1'b0 : gated;
  assign main_oe   = !act.off_main;

  AST_MAIN_HIZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !main_oe |-> !main_data); // R2
  AST_AUX_HIZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_oe && (sel != SRC_LOCK) |-> !aux_data); // R3
  AST_FORCED_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sync && m2_cfg == 3'd7) |-> (aux_oe && aux_data == pll_clk)); // R5
  AST_IDLE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_cfg inside {3'd3, 3'd4, 3'd5, 3'd6}) |-> (main_oe && (aux_src == 2'd3 || aux_oe))); // R6
endmodule

// File: tb/clkout_ctrl_tb_top.sv
module clkout_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tref_clk = 0, fref_clk = 0, pll_clk = 0;
  logic pll_locked = 0, tref_present = 0, mode_pin = 0;
  logic [2:0] m2_cfg = 0;
  logic [1:0] aux_src = 0;
  logic lock_od = 0, run_unlocked = 0;
  logic main_data, main_oe, aux_data, aux_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit en_m = 0;

  always #4 clk = ~clk;

  clkout_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tref_clk(tref_clk), .fref_clk(fref_clk),
    .pll_clk(pll_clk), .pll_locked(pll_locked), .tref_present(tref_present),
    .mode_pin(mode_pin), .m2_cfg(m2_cfg), .aux_src(aux_src), .lock_od(lock_od),
    .run_unlocked(run_unlocked), .main_data(main_data), .main_oe(main_oe),
    .aux_data(aux_data), .aux_oe(aux_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (cfg=%0d pin=%b src=%0d od=%b lk=%b tp=%b run=%b pll=%b)",
               req, act, exp, m2_cfg, mode_pin, aux_src, lock_od, pll_locked,
               tref_present, run_unlocked, pll_clk);
    end
  endtask

  // Level inputs first, then the PLL clock level; the gate model follows R10/R11
  task automatic apply(input logic [2:0] cfg, input logic pin, input logic [1:0] src,
                       input logic od, input logic lk, input logic tp, input logic run,
                       input logic tr, input logic fr, input logic pl);
    logic hold;
    m2_cfg = cfg; mode_pin = pin; aux_src = src; lock_od = od;
    pll_locked = lk; tref_present = tp; run_unlocked = run;
    tref_clk = tr; fref_clk = fr;
    hold = !lk && !run;
    if (hold) en_m = 0;
    #1;
    if (!pll_clk && pl && !hold) en_m = 1;
    pll_clk = pl;
  endtask

  task automatic expect_all(input string tag);
    logic off_m, off_a, frc, unl;
    int sel;
    logic ed, eo;
    off_m = mode_pin && (m2_cfg == 0 || m2_cfg == 2);
    off_a = mode_pin && (m2_cfg == 1 || m2_cfg == 2);
    frc   = mode_pin && (m2_cfg == 7);
    unl   = !(pll_locked && tref_present);
    sel   = frc ? 2 : int'(aux_src);
    eo = 1;
    case (sel)
      0: ed = tref_clk;
      1: ed = fref_clk;
      2: ed = pll_clk;
      default: begin
        ed = lock_od ? 1'b0 : unl;
        eo = lock_od ? unl : 1'b1;
      end
    endcase
    if (off_a) begin ed = 0; eo = 0; end
    chk({tag, " aux_data"}, aux_data, ed);
    chk({tag, " aux_oe"}, aux_oe, eo);
    chk({tag, " main_oe"}, main_oe, !off_m);
    chk({tag, " main_data"}, main_data, off_m ? 1'b0 : (pll_clk && en_m));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state with pin high and both-disable code
    apply(3'd2, 1'b1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset main_oe", main_oe, 1'b1);
    chk("R12 reset aux_oe", aux_oe, 1'b1);
    chk("R12 reset main_data", main_data, 1'b0);
    rst_n = 1'b1;
    en_m = 0;
    @(posedge clk); @(negedge clk);
    chk("R12 one edge main_oe", main_oe, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R12 two edges main_oe", main_oe, 1'b0);
    chk("R4 both aux_oe", aux_oe, 1'b0);

    // R10: resume only on a rising PLL edge after lock returns
    apply(3'd3, 1'b0, 2'd2, 0, 0, 1, 0, 0, 0, 1);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R10 held while unlocked", main_data, 1'b0);
    apply(3'd3, 1'b0, 2'd2, 0, 1, 1, 0, 0, 0, 1);
    @(negedge clk);
    chk("R10 no edge yet", main_data, 1'b0);
    apply(3'd3, 1'b0, 2'd2, 0, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    apply(3'd3, 1'b0, 2'd2, 0, 1, 1, 0, 0, 0, 1);
    @(negedge clk);
    chk("R10 resumed after edge", main_data, 1'b1);
    // R11: run while unlocked
    apply(3'd3, 1'b0, 2'd2, 0, 0, 1, 1, 0, 0, 0);
    @(negedge clk);
    apply(3'd3, 1'b0, 2'd2, 0, 0, 1, 1, 0, 0, 1);
    @(negedge clk);
    chk("R11 runs unlocked", main_data, 1'b1);

    // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 8192; v++) begin
      apply(v[2:0], v[3], v[5:4], v[6], v[7], v[8], v[9], v[10], v[11], v[12]);
      repeat (3) @(posedge clk);
      @(negedge clk);
      expect_all("R1-sweep");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule